// File: doc/BRIEF.md
# Fall-Through FIFO with Ring-Counter Pointers

This block is a small first-in first-out buffer, 16 words of 4 bits by default, driven by two level strobes instead of valid/ready handshakes. A word is taken in when the load strobe falls, and the head word is removed when the unload strobe rises. Both strobes are brought into the system clock domain through a two-flop synchroniser, and their edges are detected there. The write and read positions are one-hot ring counters. When the two pointers coincide, a stored flag tells whether the buffer is full or empty. That flag is set by the last load or unload that made the pointers meet.

The oldest stored word falls through to the data output as soon as it has been written, so a consumer sees it before it issues any unload. Two ready flags tell the producer and the consumer when a strobe will be honoured. Each flag combines the buffer state with the present level of its own strobe. An output enable forces the data output to zero and leaves both flags alone. An active-low clear empties the buffer at any time.

Top module: `ringq_fifo`

## Requirements
- R1: While `clrN` is low and right after it rises, with `loadStb` low and `unloadStb` high, `inReady` is 1, `outReady` is 0 and `dataOut` is 0. A clear in the middle of use discards every stored word.
- R2: A 1-to-0 transition of `loadStb` (idle level 0) stores `dataIn`, and a 0-to-1 transition of `unloadStb` (idle level 1) removes the head word. Each strobe must have held its level for at least 3 clock cycles before the edge. The effect is visible at the outputs no later than 4 clock cycles after the transition.
- R3: Once a word is stored in an empty buffer, `dataOut` shows it with no unload strobe. After an unload, `dataOut` shows the next word.
- R4: Words leave in the order in which they were loaded.
- R5: The buffer holds `DEPTH` (16) words. After 16 more loads than unloads it is full, and `inReady` is 0.
- R6: A load edge while the buffer is full changes neither the stored words nor their order.
- R7: An unload edge while the buffer is empty has no effect: `outReady` stays 0, and the next load is read back correctly.
- R8: `inReady` equals (not full) AND (`loadStb` = 0). `outReady` equals (not empty) AND (`unloadStb` = 1).
- R9: With `outEn` = 0, `dataOut` is all zeros, and `inReady` and `outReady` are unchanged. `dataOut` is also zero whenever the buffer is empty.
- R10: A load edge and an unload edge in the same cycle on a buffer that is neither empty nor full perform both operations. The word count stays the same.
- R11: Each pointer always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples both strobes |
| clrN | input | 1 | Active-low asynchronous clear |
| loadStb | input | 1 | Load strobe; the falling edge writes |
| unloadStb | input | 1 | Unload strobe; the rising edge reads |
| dataIn | input | WIDTH | Word to be loaded |
| outEn | input | 1 | 1 drives the head word, 0 forces zeros |
| dataOut | output | WIDTH | Oldest stored word (fall-through) |
| inReady | output | 1 | Buffer not full and load strobe low |
| outReady | output | 1 | Buffer not empty and unload strobe high |

## Verification
Some properties are checked by assertions on every cycle. Each pointer must stay one-hot. A load edge on a full buffer, or an unload edge on an empty one, must leave its pointer where it was. A word written into an empty buffer must appear at the output in the very next cycle. Other behaviour can only be shown by the bench scenarios, which run against a queue model: first-in first-out order across a complete fill and drain, silent discard of extra loads after the sixteenth, and recovery after unloading an empty buffer. The scenarios also cover a simultaneous load and unload, the clear in the middle of use, and the way the flags follow the strobe levels.

// File: rtl/ringq_pkg.sv
package ringq_pkg;
  // Per-cycle commands from the control to the storage array.
  typedef struct packed {
    logic doWrite;
    logic doRead;
  } ringq_ctl_t;
endpackage

// File: rtl/ringq_ctrl.sv
module ringq_ctrl
  import ringq_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             clrN,
  input  logic             loadStb,
  input  logic             unloadStb,
  output ringq_ctl_t       ctl,
  output logic [DEPTH-1:0] wrPtr,
  output logic [DEPTH-1:0] rdPtr,
  output logic             full,
  output logic             empty
);
  localparam int TOP = SYNC_STAGES;

  // The load strobe idles low and the unload strobe idles high, so each
  // synchroniser resets to its strobe's idle level.
  logic [TOP:0] ldSync;
  logic [TOP:0] ulSync;

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      ldSync <= '0;
      ulSync <= '1;
    end else begin
      ldSync <= {ldSync[TOP-1:0], loadStb};
      ulSync <= {ulSync[TOP-1:0], unloadStb};
    end
  end

  logic loadEdge, unloadEdge;
  assign loadEdge   = ldSync[TOP] & ~ldSync[TOP-1];
  assign unloadEdge = ~ulSync[TOP] & ulSync[TOP-1];

  // When the pointers are equal, the stored flag tells full from empty.
  logic wasFilled;
  logic ptrEq;
  assign ptrEq = (wrPtr == rdPtr);
  assign full  = ptrEq & wasFilled;
  assign empty = ptrEq & ~wasFilled;

  assign ctl.doWrite = loadEdge & ~full;
  assign ctl.doRead  = unloadEdge & ~empty;

  logic [DEPTH-1:0] wrNext, rdNext;
  assign wrNext = {wrPtr[DEPTH-2:0], wrPtr[DEPTH-1]};
  assign rdNext = {rdPtr[DEPTH-2:0], rdPtr[DEPTH-1]};

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      wrPtr     <= {{(DEPTH-1){1'b0}}, 1'b1};
      rdPtr     <= {{(DEPTH-1){1'b0}}, 1'b1};
      wasFilled <= 1'b0;
    end else begin
      if (ctl.doWrite) wrPtr <= wrNext;
      if (ctl.doRead)  rdPtr <= rdNext;
      // The pointers are one position apart and about to meet.
      if (ctl.doWrite && !ctl.doRead && wrNext == rdPtr)
        wasFilled <= 1'b1;
      else if (ctl.doRead && !ctl.doWrite && rdNext == wrPtr)
        wasFilled <= 1'b0;
    end
  end

  AST_PTR_ONEHOT: assert property (@(posedge clk) disable iff (!clrN)
    ($countones(wrPtr) == 1) && ($countones(rdPtr) == 1)); // R11

  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!clrN)
    (loadEdge && full && !unloadEdge) |=> $stable(wrPtr)); // R6

  AST_NO_READ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!clrN)
    (unloadEdge && empty && !loadEdge) |=> $stable(rdPtr)); // R7
endmodule

// File: rtl/ringq_dpath.sv
module ringq_dpath
  import ringq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clrN,
  input  ringq_ctl_t       ctl,
  input  logic [DEPTH-1:0] wrPtr,
  input  logic [DEPTH-1:0] rdPtr,
  input  logic             empty,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             outEn,
  output logic [WIDTH-1:0] dataOut
);
  logic [WIDTH-1:0] mem [DEPTH];

  // Write enables are the one-hot pointer bits, so no address decode.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (ctl.doWrite && wrPtr[i]) mem[i] <= dataIn;
    end
  end

  // Read select is an AND-OR over the one-hot read pointer.
  logic [WIDTH-1:0] headWord;
  always_comb begin
    headWord = '0;
    for (int i = 0; i < DEPTH; i++) begin
      headWord = headWord | (mem[i] & {WIDTH{rdPtr[i]}});
    end
  end

  assign dataOut = (outEn && !empty) ? headWord : '0;

  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!clrN)
    (empty && ctl.doWrite) |=> (!outEn || dataOut == $past(dataIn))); // R3
endmodule

// File: rtl/ringq_fifo.sv
module ringq_fifo
  import ringq_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             clrN,
  input  logic             loadStb,
  input  logic             unloadStb,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             outEn,
  output logic [WIDTH-1:0] dataOut,
  output logic             inReady,
  output logic             outReady
);
  ringq_ctl_t       ctl;
  logic [DEPTH-1:0] wrPtr, rdPtr;
  logic             full, empty;

  ringq_ctrl #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .clrN(clrN), .loadStb(loadStb), .unloadStb(unloadStb),
    .ctl(ctl), .wrPtr(wrPtr), .rdPtr(rdPtr), .full(full), .empty(empty)
  );

  ringq_dpath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dpath (
    .clk(clk), .clrN(clrN), .ctl(ctl), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .empty(empty), .dataIn(dataIn), .outEn(outEn), .dataOut(dataOut)
  );

  // The flags follow the live strobe levels, and the output enable
  // has no part in them.
  assign inReady  = ~full & ~loadStb;
  assign outReady = ~empty & unloadStb;
endmodule

// File: tb/ringq_fifo_bench.sv
module ringq_fifo_bench;
  localparam int DEPTH = 16;
  localparam int WIDTH = 4;

  logic clk = 1'b0;
  logic clrN, loadStb, unloadStb, outEn;
  logic [WIDTH-1:0] dataIn, dataOut;
  logic inReady, outReady;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [WIDTH-1:0] model[$];

  always #2 clk = ~clk;

  ringq_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ringq_fifo (
    .clk(clk), .clrN(clrN), .loadStb(loadStb), .unloadStb(unloadStb),
    .dataIn(dataIn), .outEn(outEn), .dataOut(dataOut),
    .inReady(inReady), .outReady(outReady)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkVal(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Scoreboard monitor: compares both flags and the head word with the model.
  task automatic checkAll(string tag);
    int expData;
    expData = (outEn && model.size() > 0) ? int'(model[0]) : 0;
    checkVal(tag, "inReady", int'(inReady),
             int'(model.size() < DEPTH && !loadStb));
    checkVal(tag, "outReady", int'(outReady),
             int'(model.size() > 0 && unloadStb));
    checkVal(tag, "dataOut", int'(dataOut), expData);
  endtask

  // Driver: a falling load edge; the expected word goes into the queue.
  task automatic loadWord(logic [WIDTH-1:0] d, string tag);
    dataIn = d;
    loadStb = 1'b1;
    tick(4);
    checkAll("R8 load strobe high");
    loadStb = 1'b0;
    tick(5);
    if (model.size() < DEPTH) model.push_back(d);
    checkAll(tag);
  endtask

  task automatic unloadWord(string tag);
    unloadStb = 1'b0;
    tick(4);
    checkAll("R8 unload strobe low");
    unloadStb = 1'b1;
    tick(5);
    if (model.size() > 0) void'(model.pop_front());
    checkAll(tag);
  endtask

  task automatic bothEdges(logic [WIDTH-1:0] d);
    dataIn = d;
    loadStb = 1'b1;
    unloadStb = 1'b0;
    tick(4);
    loadStb = 1'b0;
    unloadStb = 1'b1;
    tick(5);
    void'(model.pop_front());
    model.push_back(d);
    checkAll("R10 simultaneous load and unload");
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    clrN = 1'b0; loadStb = 1'b0; unloadStb = 1'b1; outEn = 1'b1; dataIn = '0;
    tick(3);
    checkAll("R1 during clear");
    clrN = 1'b1;
    tick(2);
    checkAll("R1 after clear");

    // r7_: unload on an empty buffer
    unloadWord("R7 unload while empty");
    loadWord(4'hA, "R3 fall-through of first word (R2 load edge)");
    loadWord(4'h5, "R2 second load");
    loadWord(4'hC, "R2 third load");

    outEn = 1'b0;
    tick(1);
    checkAll("R9 output disabled");
    checkVal("R9", "outReady with enable low", int'(outReady), 1);
    outEn = 1'b1;
    tick(1);
    checkAll("R9 output re-enabled");

    bothEdges(4'h3);
    checkVal("R10", "head after both edges", int'(dataOut), 5);

    for (int i = 0; i < 3; i++) unloadWord("R4 drain in order");

    for (int i = 0; i < DEPTH; i++)
      loadWord(4'((i * 7 + 1) & 15), "R5 fill");
    checkVal("R5", "inReady when full", int'(inReady), 0);

    loadWord(4'hF, "R6 load while full");
    loadWord(4'h0, "R6 second load while full");

    for (int i = 0; i < DEPTH; i++) unloadWord("R4 R6 drain full buffer");
    checkVal("R7", "outReady after drain", int'(outReady), 0);

    unloadWord("R7 extra unload");
    unloadWord("R7 second extra unload");
    loadWord(4'h9, "R7 load after empty unloads");
    checkVal("R3", "fall-through word", int'(dataOut), 9);

    loadWord(4'h6, "R2 load before clear");
    clrN = 1'b0;
    tick(1);
    model.delete();
    clrN = 1'b1;
    tick(2);
    checkAll("R1 clear mid-use");
    loadWord(4'h2, "R1 load after clear");
    checkVal("R1", "first word after clear", int'(dataOut), 2);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule